// File: doc/BRIEF.md
# SPI Configuration Status Poller

This block polls the status byte of a configurable device that sits behind a byte-wide SPI master. A host sequencer starts a poll by pulsing a request with an 8-bit wait mask. The poller then reads the device status as many times as it needs to. It stops when the device reports idle and, if a mask was given, when at least one of the masked status bits is set. It also stops on a reported bus fault, or when its read budget runs out.

Each status read is two separate one-byte exchanges. Both exchanges send the status opcode, and chip select is released after each byte. The reply from the first exchange is thrown away. The reply from the second exchange is taken as the status.

At the end of a poll the block raises a one-cycle done strobe. At the same time it presents the last status byte and a two-bit result code. The SPI serializer is not part of this block. It is reached through a byte handshake:

- a valid/ready pair carries the transmitted byte;
- a separate valid strobe returns the received byte;
- a flag tells the serializer whether to keep chip select asserted after the byte.

Top module: `cfg_status_poller`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `spi_tx_valid` are 0, `status_o` is 0x00 and `err_o` is 2'b00.
- R2: Every status read consists of exactly two byte transfers. Each transfer sends 0x00 on `spi_tx_data` with `spi_cs_hold` at 0, so chip select is released after each byte.
- R3: The byte returned by the first transfer of a read has no effect on the outcome, even if it has status bits 2 or 3 set. Only the byte returned by the second transfer is evaluated.
- R4: If an evaluated byte has bit 2 (violation) or bit 3 (bus error) set, the poll ends after that read with `err_o` = 2'b01 (fault).
- R5: If an evaluated byte has bit 0 (busy) clear, and either the latched mask is 0x00 or (byte AND mask) is nonzero, the poll ends with `err_o` = 2'b00.
- R6: Any other evaluated byte starts a new read, including a byte with busy clear but no masked bit set.
- R7: After MAX_READS reads without exit, the poll ends with `err_o` = 2'b10 (timeout). Exactly MAX_READS reads are made.
- R8: `req_valid` is ignored while `busy_o` is 1. The mask of the running poll is kept.
- R9: `done_o` pulses for exactly one cycle, in the cycle after the final reply is accepted. `status_o` shows that final evaluated byte. `status_o` and `err_o` change only together with `done_o`.
- R10: Once `spi_tx_valid` is raised, it stays high with unchanged data until `spi_tx_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a poll (taken only when idle) |
| req_mask | input | 8 | Wait mask for the ready test |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle end-of-poll strobe |
| status_o | output | 8 | Last evaluated status byte |
| err_o | output | 2 | 00 none, 01 fault, 10 timeout |
| spi_tx_valid | output | 1 | Byte to transmit is valid |
| spi_tx_ready | input | 1 | Serializer accepts the byte |
| spi_tx_data | output | 8 | Byte to transmit |
| spi_cs_hold | output | 1 | Keep chip select asserted after this byte |
| spi_rx_valid | input | 1 | Received byte is valid |
| spi_rx_data | input | 8 | Received byte |

## Verification
The assertions check every cycle for the following:
- the single-cycle done strobe;
- result outputs that hold between strobes;
- a transmit request that stays stable while stalled;
- consistency between the result code and the reported byte: a fault code has an error bit set, a success has busy clear.

Other behaviour can only be shown by the bench scenarios:
- that only the second reply of each pair counts;
- the exact number of reads before a timeout;
- that masked ready matching retries when it should;
- that a request raised mid-poll is dropped.

// File: rtl/cfg_status_poller.sv
module cfg_status_poller #(
  parameter int MAX_READS = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [7:0] req_mask,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] status_o,
  output logic [1:0] err_o,
  output logic       spi_tx_valid,
  input  logic       spi_tx_ready,
  output logic [7:0] spi_tx_data,
  output logic       spi_cs_hold,
  input  logic       spi_rx_valid,
  input  logic [7:0] spi_rx_data
);
  localparam int CW = $clog2(MAX_READS + 1);
  localparam logic [7:0] OP_STATUS = 8'h00;
  localparam logic [1:0] RES_OK = 2'b00, RES_FAULT = 2'b01, RES_TMO = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_TX1, S_RX1, S_TX2, S_RX2} st_t;

  st_t          st;
  logic [7:0]   mask_q;
  logic [CW-1:0] reads_q;
  logic         done_q;
  logic [7:0]   status_q;
  logic [1:0]   err_q;

  logic fault, hit, last;
  assign fault = spi_rx_data[2] | spi_rx_data[3];
  assign hit   = !spi_rx_data[0] && (mask_q == 8'h00 || |(spi_rx_data & mask_q));
  assign last  = reads_q == CW'(MAX_READS - 1);

  assign busy_o       = st != S_IDLE;
  assign spi_tx_valid = st == S_TX1 || st == S_TX2;
  assign spi_tx_data  = OP_STATUS;
  assign spi_cs_hold  = 1'b0;
  assign done_o       = done_q;
  assign status_o     = status_q;
  assign err_o        = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mask_q   <= '0;
      reads_q  <= '0;
      done_q   <= 1'b0;
      status_q <= '0;
      err_q    <= RES_OK;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          mask_q  <= req_mask;
          reads_q <= '0;
          st      <= S_TX1;
        end
        S_TX1: if (spi_tx_ready) st <= S_RX1;
        S_RX1: if (spi_rx_valid) st <= S_TX2;
        S_TX2: if (spi_tx_ready) st <= S_RX2;
        S_RX2: if (spi_rx_valid) begin
          if (fault || hit || last) begin
            done_q   <= 1'b1;
            status_q <= spi_rx_data;
            err_q    <= fault ? RES_FAULT : (hit ? RES_OK : RES_TMO);
            st       <= S_IDLE;
          end else begin
            reads_q <= reads_q + 1'b1;
            st      <= S_TX1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module cfg_status_poller_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] status_o,
  input logic [1:0] err_o,
  input logic       spi_tx_valid,
  input logic       spi_tx_ready,
  input logic [7:0] spi_tx_data
);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done_o) |-> $stable(status_o) && $stable(err_o));
  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid && !spi_tx_ready |=> spi_tx_valid && $stable(spi_tx_data));
  // R4
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && err_o == 2'b01 |-> status_o[2] || status_o[3]);
  // R5
  ok_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && err_o == 2'b00 |-> !status_o[0] && !status_o[2] && !status_o[3]);
  // R2
  tx_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid |-> busy_o);
  // R7
  err_code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o != 2'b11);
endmodule

bind cfg_status_poller cfg_status_poller_chk u_chk (.*);

// File: tb/cfg_status_poller_tb.sv
`timescale 1ns/1ps
module cfg_status_poller_tb;
  localparam int MAXR = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_mask = '0;
  logic busy_o, done_o, spi_tx_valid, spi_cs_hold;
  logic [7:0] status_o, spi_tx_data;
  logic [1:0] err_o;
  logic spi_tx_ready = 1'b0, spi_rx_valid = 1'b0;
  logic [7:0] spi_rx_data = '0;

  always #2 clk = ~clk;

  cfg_status_poller #(.MAX_READS(MAXR)) u_dut (.*);

  int checks = 0, errors = 0;
  logic [7:0] rq[$];
  logic [7:0] mdl_mask = '0;
  int mdl_reads = 0, xfer_cnt = 0, stall_cnt = 0, wcnt = 0;
  bit pend = 0, pend_second = 0, exp_done = 0, seen_done = 0, mon_on = 0, finished = 0;
  logic [7:0] exp_status = '0;
  logic [1:0] exp_err = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    // R9: done compared with model every cycle
    chk(done_o == exp_done, "R9 done timing", done_o, exp_done);
    if (exp_done) begin
      chk(status_o == exp_status, "R9 status", status_o, exp_status);
      chk(err_o == exp_err, "R4/R5/R7 err", err_o, exp_err);
      seen_done = 1;
    end
    exp_done = 0;
    stall_cnt++;
    spi_tx_ready = (stall_cnt % 3) != 0;
    spi_rx_valid = 1'b0;
    if (pend) begin
      if (wcnt == 0) begin
        logic [7:0] r;
        pend = 0;
        if (pend_second) begin
          r = (rq.size() > 0) ? rq.pop_front() : 8'h01;
          mdl_reads++;
          if (r[2] || r[3]) begin exp_done = 1; exp_err = 2'b01; end
          else if (!r[0] && (mdl_mask == 0 || (r & mdl_mask) != 0)) begin exp_done = 1; exp_err = 2'b00; end
          else if (mdl_reads == MAXR) begin exp_done = 1; exp_err = 2'b10; end
          exp_status = r;
        end else r = 8'h0C;  // R3: first reply carries error bits, must be ignored
        spi_rx_data  = r;
        spi_rx_valid = 1'b1;
      end else wcnt--;
    end
    if (spi_tx_valid && spi_tx_ready) begin
      // R2
      chk(spi_tx_data == 8'h00 && spi_cs_hold == 1'b0, "R2 opcode/cs", {spi_cs_hold, spi_tx_data}, 0);
      pend = 1; wcnt = 1; pend_second = xfer_cnt[0]; xfer_cnt++;
    end
  end

  task automatic run_poll(input logic [7:0] m, input int exp_reads, input string tag, input bit spoil);
    int x0;
    mdl_mask = m; mdl_reads = 0; xfer_cnt = 0; seen_done = 0;
    @(negedge clk); req_valid = 1'b1; req_mask = m;
    @(negedge clk); req_valid = 1'b0;
    if (spoil) begin
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_mask = 8'h40;
      @(negedge clk); req_valid = 1'b0;
    end
    while (!seen_done) @(negedge clk);
    x0 = xfer_cnt;
    repeat (4) @(negedge clk);
    chk(mdl_reads == exp_reads, {tag, " read count"}, mdl_reads, exp_reads);
    chk(x0 == 2 * exp_reads && xfer_cnt == x0, {tag, " R2 transfer count"}, xfer_cnt, 2 * exp_reads);
    chk(busy_o == 1'b0, {tag, " idle after done"}, busy_o, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1
    chk(!busy_o && !done_o && !spi_tx_valid && status_o == 0 && err_o == 0, "R1 reset", {busy_o, done_o, spi_tx_valid, err_o, status_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o, "R1 after release", {busy_o, done_o}, 0);
    mon_on = 1;
    rq = {8'h00};             run_poll(8'h00, 1, "R5 mask zero", 0);
    rq = {8'h01, 8'h03, 8'h02}; run_poll(8'h02, 3, "R6 busy retry", 0);
    rq = {8'h00, 8'h00, 8'h02}; run_poll(8'h02, 3, "R6 no mask hit", 0);
    rq = {8'h01, 8'h04};      run_poll(8'h00, 2, "R4 violation", 0);
    rq = {8'h0A};             run_poll(8'h02, 1, "R4 bus error", 0);
    rq = {8'h00, 8'h00};      run_poll(8'h00, 1, "R3 first reply ignored", 0);
    rq.delete();              run_poll(8'h00, MAXR, "R7 timeout busy", 0);
    rq = {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}; run_poll(8'h80, MAXR, "R7 timeout nomatch", 0);
    rq = {8'h01, 8'h40, 8'h01, 8'h02}; run_poll(8'h02, 4, "R8 request ignored", 1);
    finish_run();
  end
endmodule